// File: doc/BRIEF.md
# MESI Snooping Coherence Controller

This block keeps one private write-back cache coherent with its peers on a shared bus on which every transaction is seen by all caches in one global order. For each line of a small direct-mapped tag array it holds one of four states: invalid, shared (clean, other copies may exist), exclusive (clean, sole copy) and modified (dirty, sole copy). It also holds one data word per line. Local loads and stores are served from the array when the state allows. Otherwise the controller asks for the bus and issues a read, a read-for-ownership or an upgrade. A dirty line that must be replaced is first written back.

Remote transactions arrive on a snoop port. The controller looks up the addressed line. In the cycle after the snoop it reports whether the line is held, returns the data when it owns the line, and moves the line down the protocol. A fill answer carries a shared flag. With that flag the controller installs a loaded line as exclusive when no other cache holds it, so a later private store needs no bus traffic.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: A load that misses issues a bus read (command code 0) for the request address. The line is installed as exclusive when the fill's shared flag is 0 and as shared when it is 1. The loaded word is returned to the requester in the cycle after the fill.
- R2: A store that misses issues a read-for-ownership (command code 1). The line ends modified and holds the store data, not the fill data.
- R3: A store to a shared line issues an upgrade (command code 2) with no fill phase. On grant the line ends modified with the store data.
- R4: A store to an exclusive line completes locally, with no bus request, and leaves the line modified.
- R5: A snoop read (code 0) that hits a modified or exclusive line returns the line's word with the supply flag set and leaves the line shared. The memory-update flag is set only when the line was modified.
- R6: A snoop read-for-ownership (code 1) that hits a modified or exclusive line returns the word with the supply flag set and invalidates the line.
- R7: A snoop read-for-ownership or upgrade (code 2) that hits a shared line invalidates it without supplying data. A snoop read that hits a shared line leaves it shared without supplying data.
- R8: Loads that hit, and stores that hit a modified line, answer in the cycle after acceptance with no bus request.
- R9: A miss whose slot holds a modified line of another address first issues a writeback (command code 3) of the old address and word. A slot holding a clean line is replaced without a writeback.
- R10: The shared snoop output is 1 exactly when a snoop read found the line valid. It is 0 for snoops that miss and for non-read snoops.
- R11: If a snoop invalidates the shared line while an upgrade is still waiting for grant, the request is reissued as a read-for-ownership and completes with a fill.
- R12: After reset every line is invalid, no bus request is raised, all snoop outputs are 0 and the request port is ready.
- R13: A pending bus request keeps its command and address until granted, unless a snoop changes the line it depends on.
- R14: Local requests are not accepted in a cycle with a snoop, or while a miss is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Local request present |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | AW | Local word address |
| cpu_req_wdata | input | DW | Store data |
| cpu_req_ready | output | 1 | Request accepted this cycle when valid |
| cpu_resp_valid | output | 1 | One-cycle completion pulse |
| cpu_resp_rdata | output | DW | Line word after the operation |
| bus_req_valid | output | 1 | Bus request pending |
| bus_req_cmd | output | 2 | 0 read, 1 read-for-ownership, 2 upgrade, 3 writeback |
| bus_req_addr | output | AW | Address of the request |
| bus_req_data | output | DW | Writeback word |
| bus_gnt | input | 1 | Request granted this cycle |
| bus_fill_valid | input | 1 | Fill word for a granted read or read-for-ownership |
| bus_fill_data | input | DW | Fill word |
| bus_fill_shared | input | 1 | Another cache holds the filled line |
| snp_valid | input | 1 | Remote transaction observed |
| snp_cmd | input | 2 | Remote command, same codes as bus_req_cmd |
| snp_addr | input | AW | Remote address |
| snp_shared | output | 1 | Snoop read found the line valid |
| snp_supply | output | 1 | This cache drives the data |
| snp_data | output | DW | Supplied word |
| snp_mem_update | output | 1 | Supplied word is dirty and memory takes it |

## Verification
Local traffic is applied as load and store hits on each of the three valid states and as misses with the fill's shared flag at 0 and at 1. The outcome is read back through later snoops, so that exclusive, shared and modified lines are told apart by the supply and memory-update flags. Conflict misses on one slot are tried with a dirty victim and with a clean victim, which separates a writeback from a silent replacement. Remote reads, reads-for-ownership and upgrades are aimed at every state. An upgrade is also invalidated while it waits for grant, to show the reissue as a read-for-ownership.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

   typedef enum logic [1:0] {
      LN_INV = 2'd0,
      LN_SHR = 2'd1,
      LN_EXC = 2'd2,
      LN_MOD = 2'd3
   } line_st_e;

   typedef enum logic [1:0] {
      BC_READ  = 2'd0,
      BC_OWN   = 2'd1,
      BC_UPGR  = 2'd2,
      BC_WBACK = 2'd3
   } bus_cmd_e;

   typedef enum logic [2:0] {
      FS_IDLE  = 3'd0,
      FS_WBACK = 3'd1,
      FS_REQ   = 3'd2,
      FS_WAIT  = 3'd3,
      FS_UPGR  = 3'd4
   } fsm_e;

endpackage

// File: rtl/mesi_line_array.sv
module mesi_line_array
   import mesi_pkg::*;
#(
   parameter int LINES = 8,
   parameter int IW    = 3,
   parameter int TAGW  = 5,
   parameter int DW    = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [IW-1:0]   a_idx,
   output line_st_e        a_st,
   output logic [TAGW-1:0] a_tag,
   output logic [DW-1:0]   a_data,
   input  logic [IW-1:0]   b_idx,
   output line_st_e        b_st,
   output logic [TAGW-1:0] b_tag,
   output logic [DW-1:0]   b_data,
   input  logic            lw_en,
   input  logic [IW-1:0]   lw_idx,
   input  line_st_e        lw_st,
   input  logic [TAGW-1:0] lw_tag,
   input  logic [DW-1:0]   lw_data,
   input  logic            sw_en,
   input  logic [IW-1:0]   sw_idx,
   input  line_st_e        sw_st
);

   line_st_e        st_q  [LINES];
   logic [TAGW-1:0] tag_q [LINES];
   logic [DW-1:0]   dat_q [LINES];

   // one register set per line; the local port wins over the snoop port
   for (genvar i = 0; i < LINES; i++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_q[i]  <= LN_INV;
            tag_q[i] <= '0;
            dat_q[i] <= '0;
         end else if (lw_en && lw_idx == IW'(i)) begin
            st_q[i]  <= lw_st;
            tag_q[i] <= lw_tag;
            dat_q[i] <= lw_data;
         end else if (sw_en && sw_idx == IW'(i)) begin
            st_q[i]  <= sw_st;
         end
      end
   end

   assign a_st   = st_q[a_idx];
   assign a_tag  = tag_q[a_idx];
   assign a_data = dat_q[a_idx];
   assign b_st   = st_q[b_idx];
   assign b_tag  = tag_q[b_idx];
   assign b_data = dat_q[b_idx];

endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
   import mesi_pkg::*;
#(
   parameter int AW   = 8,
   parameter int IW   = 3,
   parameter int TAGW = 5,
   parameter int DW   = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            snp_valid,
   input  logic [1:0]      snp_cmd,
   input  logic [AW-1:0]   snp_addr,
   output logic [IW-1:0]   look_idx,
   input  line_st_e        ln_st,
   input  logic [TAGW-1:0] ln_tag,
   input  logic [DW-1:0]   ln_data,
   output logic            sw_en,
   output line_st_e        sw_st,
   output logic            snp_shared,
   output logic            snp_supply,
   output logic [DW-1:0]   snp_data,
   output logic            snp_mem_update
);

   logic     hit;
   logic     owner;
   logic     sh_d, sup_d, mu_d;
   bus_cmd_e cmd;

   assign look_idx = snp_addr[IW-1:0];
   assign cmd      = bus_cmd_e'(snp_cmd);
   assign hit      = snp_valid && (ln_st != LN_INV) && (ln_tag == snp_addr[AW-1:IW]);
   assign owner    = (ln_st == LN_MOD) || (ln_st == LN_EXC);

   always_comb begin
      sw_en = 1'b0;
      sw_st = ln_st;
      sh_d  = 1'b0;
      sup_d = 1'b0;
      mu_d  = 1'b0;
      if (hit) begin
         unique case (cmd)
            BC_READ: begin
               sh_d = 1'b1;
               if (owner) begin
                  sup_d = 1'b1;
                  mu_d  = (ln_st == LN_MOD);
                  sw_en = 1'b1;
                  sw_st = LN_SHR;
               end
            end
            BC_OWN: begin
               sup_d = owner;
               sw_en = 1'b1;
               sw_st = LN_INV;
            end
            BC_UPGR: begin
               sw_en = 1'b1;
               sw_st = LN_INV;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snp_shared     <= 1'b0;
         snp_supply     <= 1'b0;
         snp_mem_update <= 1'b0;
         snp_data       <= '0;
      end else begin
         snp_shared     <= sh_d;
         snp_supply     <= sup_d;
         snp_mem_update <= mu_d;
         snp_data       <= sup_d ? ln_data : '0;
      end
   end

endmodule

// File: rtl/mesi_req_fsm.sv
module mesi_req_fsm
   import mesi_pkg::*;
#(
   parameter int AW   = 8,
   parameter int IW   = 3,
   parameter int TAGW = 5,
   parameter int DW   = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cpu_req_valid,
   input  logic            cpu_req_write,
   input  logic [AW-1:0]   cpu_req_addr,
   input  logic [DW-1:0]   cpu_req_wdata,
   output logic            cpu_req_ready,
   output logic            cpu_resp_valid,
   output logic [DW-1:0]   cpu_resp_rdata,
   input  logic            snp_valid,
   output logic [IW-1:0]   look_idx,
   input  line_st_e        ln_st,
   input  logic [TAGW-1:0] ln_tag,
   input  logic [DW-1:0]   ln_data,
   output logic            lw_en,
   output line_st_e        lw_st,
   output logic [TAGW-1:0] lw_tag,
   output logic [DW-1:0]   lw_data,
   output logic            bus_req_valid,
   output logic [1:0]      bus_req_cmd,
   output logic [AW-1:0]   bus_req_addr,
   output logic [DW-1:0]   bus_req_data,
   input  logic            bus_gnt,
   input  logic            bus_fill_valid,
   input  logic [DW-1:0]   bus_fill_data,
   input  logic            bus_fill_shared
);

   fsm_e            state_q, state_d;
   bus_cmd_e        cmd_q, cmd_d;
   logic            we_q;
   logic [AW-1:0]   addr_q;
   logic [DW-1:0]   wdata_q;
   logic [TAGW-1:0] vtag_q;
   logic            resp_d;
   logic [DW-1:0]   rdata_q, rdata_d;
   logic [TAGW-1:0] cur_tag;
   logic            hit;
   logic            accept;

   assign cpu_req_ready = (state_q == FS_IDLE) && !snp_valid;
   assign accept        = cpu_req_valid && cpu_req_ready;
   assign look_idx      = (state_q == FS_IDLE) ? cpu_req_addr[IW-1:0] : addr_q[IW-1:0];
   assign cur_tag       = (state_q == FS_IDLE) ? cpu_req_addr[AW-1:IW] : addr_q[AW-1:IW];
   assign hit           = (ln_st != LN_INV) && (ln_tag == cur_tag);

   always_comb begin
      state_d       = state_q;
      cmd_d         = cmd_q;
      lw_en         = 1'b0;
      lw_st         = ln_st;
      lw_tag        = ln_tag;
      lw_data       = ln_data;
      resp_d        = 1'b0;
      rdata_d       = rdata_q;
      bus_req_valid = 1'b0;
      bus_req_cmd   = cmd_q;
      bus_req_addr  = addr_q;
      bus_req_data  = '0;
      unique case (state_q)
         FS_IDLE: begin
            if (accept) begin
               if (hit && !cpu_req_write) begin
                  resp_d  = 1'b1;
                  rdata_d = ln_data;
               end else if (hit && ln_st == LN_SHR) begin
                  state_d = FS_UPGR;
                  cmd_d   = BC_UPGR;
               end else if (hit) begin
                  // exclusive or modified: silent move to modified
                  lw_en   = 1'b1;
                  lw_st   = LN_MOD;
                  lw_data = cpu_req_wdata;
                  resp_d  = 1'b1;
                  rdata_d = cpu_req_wdata;
               end else begin
                  cmd_d   = cpu_req_write ? BC_OWN : BC_READ;
                  state_d = (ln_st == LN_MOD) ? FS_WBACK : FS_REQ;
               end
            end
         end
         FS_WBACK: begin
            if (ln_st != LN_MOD || ln_tag != vtag_q) begin
               state_d = FS_REQ;
            end else begin
               bus_req_valid = 1'b1;
               bus_req_cmd   = BC_WBACK;
               bus_req_addr  = {vtag_q, addr_q[IW-1:0]};
               bus_req_data  = ln_data;
               if (bus_gnt) begin
                  lw_en   = 1'b1;
                  lw_st   = LN_INV;
                  state_d = FS_REQ;
               end
            end
         end
         FS_REQ: begin
            bus_req_valid = 1'b1;
            if (bus_gnt) state_d = FS_WAIT;
         end
         FS_WAIT: begin
            if (bus_fill_valid) begin
               lw_en  = 1'b1;
               lw_tag = addr_q[AW-1:IW];
               if (we_q) begin
                  lw_st   = LN_MOD;
                  lw_data = wdata_q;
               end else begin
                  lw_st   = bus_fill_shared ? LN_SHR : LN_EXC;
                  lw_data = bus_fill_data;
               end
               resp_d  = 1'b1;
               rdata_d = we_q ? wdata_q : bus_fill_data;
               state_d = FS_IDLE;
            end
         end
         FS_UPGR: begin
            if (hit && ln_st == LN_SHR) begin
               bus_req_valid = 1'b1;
               bus_req_cmd   = BC_UPGR;
               if (bus_gnt) begin
                  lw_en   = 1'b1;
                  lw_st   = LN_MOD;
                  lw_data = wdata_q;
                  resp_d  = 1'b1;
                  rdata_d = wdata_q;
                  state_d = FS_IDLE;
               end
            end else begin
               // copy lost to a remote writer: ownership must be fetched
               state_d = FS_REQ;
               cmd_d   = BC_OWN;
            end
         end
         default: state_d = FS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q        <= FS_IDLE;
         cmd_q          <= BC_READ;
         we_q           <= 1'b0;
         addr_q         <= '0;
         wdata_q        <= '0;
         vtag_q         <= '0;
         rdata_q        <= '0;
         cpu_resp_valid <= 1'b0;
      end else begin
         state_q        <= state_d;
         cmd_q          <= cmd_d;
         rdata_q        <= rdata_d;
         cpu_resp_valid <= resp_d;
         if (accept) begin
            we_q    <= cpu_req_write;
            addr_q  <= cpu_req_addr;
            wdata_q <= cpu_req_wdata;
            vtag_q  <= ln_tag;
         end
      end
   end

   assign cpu_resp_rdata = rdata_q;

endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
   import mesi_pkg::*;
#(
   parameter int AW    = 8,
   parameter int DW    = 16,
   parameter int LINES = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cpu_req_valid,
   input  logic          cpu_req_write,
   input  logic [AW-1:0] cpu_req_addr,
   input  logic [DW-1:0] cpu_req_wdata,
   output logic          cpu_req_ready,
   output logic          cpu_resp_valid,
   output logic [DW-1:0] cpu_resp_rdata,
   output logic          bus_req_valid,
   output logic [1:0]    bus_req_cmd,
   output logic [AW-1:0] bus_req_addr,
   output logic [DW-1:0] bus_req_data,
   input  logic          bus_gnt,
   input  logic          bus_fill_valid,
   input  logic [DW-1:0] bus_fill_data,
   input  logic          bus_fill_shared,
   input  logic          snp_valid,
   input  logic [1:0]    snp_cmd,
   input  logic [AW-1:0] snp_addr,
   output logic          snp_shared,
   output logic          snp_supply,
   output logic [DW-1:0] snp_data,
   output logic          snp_mem_update
);

   localparam int IW   = $clog2(LINES);
   localparam int TAGW = AW - IW;

   if (LINES < 2 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
      $error("LINES must be a power of two of at least 2");
   end
   if (TAGW < 1) begin : g_bad_aw
      $error("AW must exceed the index width");
   end
   if (DW < 1) begin : g_bad_dw
      $error("DW must be positive");
   end

   logic [IW-1:0]   a_idx, b_idx;
   line_st_e        a_st, b_st, lw_st, sw_st;
   logic [TAGW-1:0] a_tag, b_tag, lw_tag;
   logic [DW-1:0]   a_data, b_data, lw_data;
   logic            lw_en, sw_en;

   mesi_line_array #(.LINES(LINES), .IW(IW), .TAGW(TAGW), .DW(DW)) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .a_idx   (a_idx),
      .a_st    (a_st),
      .a_tag   (a_tag),
      .a_data  (a_data),
      .b_idx   (b_idx),
      .b_st    (b_st),
      .b_tag   (b_tag),
      .b_data  (b_data),
      .lw_en   (lw_en),
      .lw_idx  (a_idx),
      .lw_st   (lw_st),
      .lw_tag  (lw_tag),
      .lw_data (lw_data),
      .sw_en   (sw_en),
      .sw_idx  (b_idx),
      .sw_st   (sw_st)
   );

   mesi_snoop_unit #(.AW(AW), .IW(IW), .TAGW(TAGW), .DW(DW)) u_snoop (
      .clk            (clk),
      .rst_n          (rst_n),
      .snp_valid      (snp_valid),
      .snp_cmd        (snp_cmd),
      .snp_addr       (snp_addr),
      .look_idx       (b_idx),
      .ln_st          (b_st),
      .ln_tag         (b_tag),
      .ln_data        (b_data),
      .sw_en          (sw_en),
      .sw_st          (sw_st),
      .snp_shared     (snp_shared),
      .snp_supply     (snp_supply),
      .snp_data       (snp_data),
      .snp_mem_update (snp_mem_update)
   );

   mesi_req_fsm #(.AW(AW), .IW(IW), .TAGW(TAGW), .DW(DW)) u_fsm (
      .clk             (clk),
      .rst_n           (rst_n),
      .cpu_req_valid   (cpu_req_valid),
      .cpu_req_write   (cpu_req_write),
      .cpu_req_addr    (cpu_req_addr),
      .cpu_req_wdata   (cpu_req_wdata),
      .cpu_req_ready   (cpu_req_ready),
      .cpu_resp_valid  (cpu_resp_valid),
      .cpu_resp_rdata  (cpu_resp_rdata),
      .snp_valid       (snp_valid),
      .look_idx        (a_idx),
      .ln_st           (a_st),
      .ln_tag          (a_tag),
      .ln_data         (a_data),
      .lw_en           (lw_en),
      .lw_st           (lw_st),
      .lw_tag          (lw_tag),
      .lw_data         (lw_data),
      .bus_req_valid   (bus_req_valid),
      .bus_req_cmd     (bus_req_cmd),
      .bus_req_addr    (bus_req_addr),
      .bus_req_data    (bus_req_data),
      .bus_gnt         (bus_gnt),
      .bus_fill_valid  (bus_fill_valid),
      .bus_fill_data   (bus_fill_data),
      .bus_fill_shared (bus_fill_shared)
   );

endmodule

// File: rtl/mesi_snoop_ctrl_chk.sv
module mesi_snoop_ctrl_chk #(
   parameter int AW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          snp_valid,
   input logic [1:0]    snp_cmd,
   input logic          snp_shared,
   input logic          snp_supply,
   input logic          snp_mem_update,
   input logic          bus_req_valid,
   input logic [1:0]    bus_req_cmd,
   input logic [AW-1:0] bus_req_addr,
   input logic          bus_gnt,
   input logic          cpu_req_ready,
   input logic          cpu_resp_valid
);

   AST_DIRTY_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
      snp_mem_update |-> snp_supply); // R5

   AST_SHARED_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      snp_shared |-> ($past(snp_valid) && $past(snp_cmd) == 2'd0)); // R10

   AST_SUPPLY_ON_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
      snp_supply |-> ($past(snp_valid) && $past(snp_cmd) <= 2'd1)); // R6

   AST_READY_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req_ready |-> !bus_req_valid); // R14

   AST_RESP_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_resp_valid |-> !bus_req_valid); // R8

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_valid && !bus_gnt && !snp_valid) |=>
         (bus_req_valid && $stable(bus_req_cmd) && $stable(bus_req_addr))); // R13

endmodule

bind mesi_snoop_ctrl mesi_snoop_ctrl_chk #(.AW(AW)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .snp_valid      (snp_valid),
   .snp_cmd        (snp_cmd),
   .snp_shared     (snp_shared),
   .snp_supply     (snp_supply),
   .snp_mem_update (snp_mem_update),
   .bus_req_valid  (bus_req_valid),
   .bus_req_cmd    (bus_req_cmd),
   .bus_req_addr   (bus_req_addr),
   .bus_gnt        (bus_gnt),
   .cpu_req_ready  (cpu_req_ready),
   .cpu_resp_valid (cpu_resp_valid)
);

// File: tb/mesi_snoop_ctrl_test.sv
module mesi_snoop_ctrl_test;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 8;
   localparam int DW = 16;

   localparam logic [1:0] C_RD = 2'd0, C_OWN = 2'd1, C_UPG = 2'd2, C_WB = 2'd3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
   logic [AW-1:0] cpu_req_addr = '0;
   logic [DW-1:0] cpu_req_wdata = '0;
   logic          cpu_req_ready, cpu_resp_valid;
   logic [DW-1:0] cpu_resp_rdata;
   logic          bus_req_valid;
   logic [1:0]    bus_req_cmd;
   logic [AW-1:0] bus_req_addr;
   logic [DW-1:0] bus_req_data;
   logic          bus_gnt = 1'b0, bus_fill_valid = 1'b0, bus_fill_shared = 1'b0;
   logic [DW-1:0] bus_fill_data = '0;
   logic          snp_valid = 1'b0;
   logic [1:0]    snp_cmd = '0;
   logic [AW-1:0] snp_addr = '0;
   logic          snp_shared, snp_supply, snp_mem_update;
   logic [DW-1:0] snp_data;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [DW-1:0] exp_q[$];
   string         tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   mesi_snoop_ctrl #(.AW(AW), .DW(DW), .LINES(8)) uut (.*);

   task automatic chk(input string rq, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   // monitor: pops the scoreboard on every completion pulse
   always @(negedge clk) begin
      if (rst_n && cpu_resp_valid) begin
         if (exp_q.size() == 0) begin
            chk("R8", "unexpected response", 1, 0);
         end else begin
            automatic logic [DW-1:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            chk(t, "response data", int'(cpu_resp_rdata), int'(e));
         end
      end
   end

   task automatic cpu_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                         input logic [DW-1:0] exp_rd, input string rq);
      exp_q.push_back(exp_rd);
      tag_q.push_back(rq);
      @(negedge clk);
      chk("R14", "ready before request", int'(cpu_req_ready), 1);
      cpu_req_valid = 1'b1;
      cpu_req_write = we;
      cpu_req_addr  = a;
      cpu_req_wdata = wd;
      @(posedge clk);
      @(negedge clk);
      cpu_req_valid = 1'b0;
   endtask

   task automatic bus_serve(input logic [1:0] cmd, input logic [AW-1:0] a, input logic [DW-1:0] wb,
                            input logic [DW-1:0] fill, input bit sh, input string rq);
      for (int n = 0; n < 40 && !bus_req_valid; n++) @(negedge clk);
      chk(rq, "bus request", int'(bus_req_valid), 1);
      chk(rq, "bus command", int'(bus_req_cmd), int'(cmd));
      chk(rq, "bus address", int'(bus_req_addr), int'(a));
      if (cmd == C_WB) chk(rq, "writeback data", int'(bus_req_data), int'(wb));
      bus_gnt = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_gnt = 1'b0;
      if (cmd == C_RD || cmd == C_OWN) begin
         bus_fill_valid  = 1'b1;
         bus_fill_data   = fill;
         bus_fill_shared = sh;
         @(posedge clk);
         @(negedge clk);
         bus_fill_valid = 1'b0;
      end
   endtask

   task automatic no_bus(input string rq);
      chk(rq, "no bus request", int'(bus_req_valid), 0);
   endtask

   task automatic snoop(input logic [1:0] cmd, input logic [AW-1:0] a, input bit sh, input bit sup,
                        input logic [DW-1:0] d, input bit mu, input string rq);
      snp_valid = 1'b1;
      snp_cmd   = cmd;
      snp_addr  = a;
      @(posedge clk);
      @(negedge clk);
      snp_valid = 1'b0;
      chk(rq, "snoop shared", int'(snp_shared), int'(sh));
      chk(rq, "snoop supply", int'(snp_supply), int'(sup));
      chk(rq, "snoop memory update", int'(snp_mem_update), int'(mu));
      if (sup) chk(rq, "snoop data", int'(snp_data), int'(d));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R12: reset state
      chk("R12", "ready", int'(cpu_req_ready), 1);
      chk("R12", "bus idle", int'(bus_req_valid), 0);
      chk("R12", "snoop outputs", int'({snp_shared, snp_supply, snp_mem_update}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      snoop(C_RD, 8'h10, 0, 0, 0, 0, "R12");

      // R1 exclusive fill, R8 load hit, R4 silent store
      cpu_op(0, 8'h11, 0, 16'hA011, "R1");
      bus_serve(C_RD, 8'h11, 0, 16'hA011, 0, "R1");
      cpu_op(0, 8'h11, 0, 16'hA011, "R8");
      no_bus("R8");
      cpu_op(1, 8'h11, 16'hB011, 16'hB011, "R4");
      no_bus("R4");
      snoop(C_RD, 8'h11, 1, 1, 16'hB011, 1, "R5");
      snoop(C_RD, 8'h11, 1, 0, 0, 0, "R7");
      // R3 upgrade from shared
      cpu_op(1, 8'h11, 16'hC011, 16'hC011, "R3");
      bus_serve(C_UPG, 8'h11, 0, 0, 0, "R3");
      snoop(C_OWN, 8'h11, 0, 1, 16'hC011, 0, "R6");
      snoop(C_RD, 8'h11, 0, 0, 0, 0, "R6");

      // R1 shared fill, R7 remote upgrade
      cpu_op(0, 8'h22, 0, 16'h2222, "R1");
      bus_serve(C_RD, 8'h22, 0, 16'h2222, 1, "R1");
      snoop(C_RD, 8'h22, 1, 0, 0, 0, "R1");
      snoop(C_UPG, 8'h22, 0, 0, 0, 0, "R7");
      snoop(C_RD, 8'h22, 0, 0, 0, 0, "R7");

      // R5 clean owner read, R7 remote ownership to shared
      cpu_op(0, 8'h33, 0, 16'h3333, "R1");
      bus_serve(C_RD, 8'h33, 0, 16'h3333, 0, "R1");
      snoop(C_RD, 8'h33, 1, 1, 16'h3333, 0, "R5");
      snoop(C_OWN, 8'h33, 0, 0, 0, 0, "R7");
      snoop(C_RD, 8'h33, 0, 0, 0, 0, "R7");
      // R6 ownership snoop on exclusive, R10 shared stays low
      cpu_op(0, 8'h44, 0, 16'h4444, "R1");
      bus_serve(C_RD, 8'h44, 0, 16'h4444, 0, "R1");
      snoop(C_OWN, 8'h44, 0, 1, 16'h4444, 0, "R10");
      snoop(C_RD, 8'h44, 0, 0, 0, 0, "R6");

      // R2 store miss keeps store data
      cpu_op(1, 8'h55, 16'h5555, 16'h5555, "R2");
      bus_serve(C_OWN, 8'h55, 0, 16'h9999, 0, "R2");
      // R9 dirty victim written back first
      cpu_op(0, 8'h75, 0, 16'h7575, "R9");
      bus_serve(C_WB, 8'h55, 16'h5555, 0, 0, "R9");
      bus_serve(C_RD, 8'h75, 0, 16'h7575, 0, "R9");
      snoop(C_RD, 8'h55, 0, 0, 0, 0, "R9");
      // R9 clean victim replaced silently
      cpu_op(0, 8'h95, 0, 16'h9595, "R9");
      bus_serve(C_RD, 8'h95, 0, 16'h9595, 1, "R9");

      // R11 upgrade lost to a remote upgrade
      cpu_op(1, 8'h95, 16'hD095, 16'hD095, "R11");
      chk("R11", "upgrade pending", int'(bus_req_valid), 1);
      chk("R11", "upgrade command", int'(bus_req_cmd), int'(C_UPG));
      snoop(C_UPG, 8'h95, 0, 0, 0, 0, "R11");
      bus_serve(C_OWN, 8'h95, 0, 16'h1111, 0, "R11");
      // R8 store hit on modified
      cpu_op(1, 8'h95, 16'hE095, 16'hE095, "R8");
      no_bus("R8");
      snoop(C_RD, 8'h95, 1, 1, 16'hE095, 1, "R5");

      repeat (3) @(negedge clk);
      chk("R8", "scoreboard drained", exp_q.size(), 0);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

endmodule